// File: doc/BRIEF.md
# Frontend register rename table

This block is the speculative rename map at the front of an out-of-order core. It holds one physical-register tag for every architectural register. Each rename request names a destination architectural register together with a freshly allocated physical tag, and two source architectural registers. In the same cycle the block answers with the physical tags currently bound to the two sources. On the following clock edge it binds the destination to its new tag.

The lookups of a request happen before its own update. A source that names the same register as the destination therefore sees the tag that was bound before the request. Register 0 is hard-wired to tag 0. The request side uses a valid/ready handshake. Ready is high whenever reset is not asserted, and the answer is combinational in the cycle the request is presented.

Top module: `rename_map`

## Requirements
- R1: The source tag outputs always show the tags currently bound to the two named source registers, combinationally, whether or not the request is valid.
- R2: When a source index equals the destination index of the same accepted request, that source returns the tag bound before the request. The new tag is seen only from the next cycle on.
- R3: While reset is asserted, and after it is released, every architectural register is bound to tag 0 until it is renamed.
- R4: A lookup of register 0 always returns tag 0. An accepted request whose destination is register 0 changes no binding.
- R5: An accepted request (valid and ready both high at a rising edge) with a nonzero destination binds that destination to the given tag. The binding is visible to every later request.
- R6: A cycle with valid low changes no binding.
- R7: Ready is low while reset is asserted and high otherwise.
- R8: An accepted request changes only the binding of its own destination register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A rename request is presented |
| req_ready | output | 1 | The block accepts a request this cycle |
| dst_idx | input | IDX_W | Destination architectural register |
| dst_tag | input | TAG_W | Newly allocated physical tag for the destination |
| src_a_idx | input | IDX_W | First source architectural register |
| src_b_idx | input | IDX_W | Second source architectural register |
| src_a_tag | output | TAG_W | Physical tag currently bound to the first source |
| src_b_tag | output | TAG_W | Physical tag currently bound to the second source |

## Verification
The hardest situation to reach from the ports is a request whose source equals its own destination, made while that register already holds a nonzero tag. Uniform random stimulus over 32 registers lands there only rarely. The bench forces the case with directed sequences: first a rename of a register, then a request that both reads and rewrites it, then a request that reads it again. It also biases a share of the random traffic so that one source copies the destination. A per-cycle reference array follows every accepted request and is compared against both source outputs on every clock.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int LREGS = 32,
  parameter int TAG_W = 5,
  localparam int IDX_W = (LREGS > 1) ? $clog2(LREGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [TAG_W-1:0] dst_tag,
  input  logic [IDX_W-1:0] src_a_idx,
  input  logic [IDX_W-1:0] src_b_idx,
  output logic [TAG_W-1:0] src_a_tag,
  output logic [TAG_W-1:0] src_b_tag
);

  logic [LREGS-1:0][TAG_W-1:0] map_q;
  logic fire;

  assign req_ready = rst_n;
  assign fire      = req_valid && req_ready;

  function automatic logic [TAG_W-1:0] lookup(input logic [IDX_W-1:0] idx,
                                              input logic [LREGS-1:0][TAG_W-1:0] m);
    lookup = '0;
    if (int'(idx) < LREGS) lookup = m[idx];
  endfunction

  assign src_a_tag = lookup(src_a_idx, map_q);
  assign src_b_tag = lookup(src_b_idx, map_q);

  for (genvar g = 0; g < LREGS; g++) begin : g_entry
    if (g == 0) begin : g_zero
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) map_q[g] <= '0;
        else        map_q[g] <= '0;
    end else begin : g_live
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                             map_q[g] <= '0;
        else if (fire && int'(dst_idx) == g)    map_q[g] <= dst_tag;
    end
  end

  p_zero_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_idx == '0) |-> (src_a_tag == '0));

  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dst_idx != '0 && int'(dst_idx) < LREGS) |=> (map_q[$past(dst_idx)] == $past(dst_tag)));

  p_old_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dst_idx != '0) |=>
      ((src_b_idx == $past(dst_idx)) -> (src_b_tag == $past(dst_tag))));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid) |=> $stable(map_q));

  p_zero_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dst_idx == '0) |=> $stable(map_q));

endmodule

// File: tb/tb_rename_map.sv
module tb_rename_map;
  localparam int LREGS = 32;
  localparam int TAG_W = 5;
  localparam int IDX_W = $clog2(LREGS);

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic req_ready;
  logic [IDX_W-1:0] dst_idx = '0, src_a_idx = '0, src_b_idx = '0;
  logic [TAG_W-1:0] dst_tag = '0, src_a_tag, src_b_tag;

  int model [LREGS];
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rename_map #(.LREGS(LREGS), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .dst_idx(dst_idx), .dst_tag(dst_tag), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .src_a_tag(src_a_tag), .src_b_tag(src_b_tag));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at negedge, check before posedge, update model at posedge.
  task automatic step(bit v, int d, int t, int a, int b, string req);
    @(negedge clk);
    req_valid = v; dst_idx = IDX_W'(d); dst_tag = TAG_W'(t);
    src_a_idx = IDX_W'(a); src_b_idx = IDX_W'(b);
    #2;
    check({req, " src_a (R1)"}, int'(src_a_tag), model[a]);
    check({req, " src_b (R1)"}, int'(src_b_tag), model[b]);
    check("R7 ready", int'(req_ready), 1);
    @(posedge clk);
    if (v && d != 0) model[d] = t;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LREGS; i++) model[i] = 0;
    #3;
    check("R7 ready in reset", int'(req_ready), 0);
    check("R3 reset read", int'(src_a_tag), 0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < LREGS; i += 2) step(0, 0, 0, i, i + 1, "R3 sweep");

    step(1, 5, 7, 1, 2, "R5 write");
    step(1, 5, 9, 5, 5, "R2 self");
    step(0, 0, 0, 5, 0, "R2 after");
    check("R2 new tag", int'(src_a_tag), 9);
    step(0, 5, 3, 5, 5, "R6 idle");
    check("R6 unchanged", int'(src_b_tag), 9);
    step(1, 0, 17, 0, 0, "R4 dst zero");
    step(0, 0, 0, 0, 5, "R4 after");
    check("R4 zero stays", int'(src_a_tag), 0);
    step(1, 6, 4, 5, 6, "R8 neighbour");
    step(0, 0, 0, 5, 6, "R8 after");
    check("R8 other kept", int'(src_a_tag), 9);

    for (int n = 0; n < 3000; n++) begin
      int d, a, b, t;
      bit v;
      d = $urandom_range(LREGS - 1);
      t = $urandom_range((1 << TAG_W) - 1, 1);
      a = $urandom_range(LREGS - 1);
      b = ($urandom_range(3) == 0) ? d : $urandom_range(LREGS - 1);
      v = ($urandom_range(4) != 0);
      step(v, d, t, a, b, "R5 random");
    end

    for (int i = 0; i < LREGS; i += 2) step(0, 0, 0, i, i + 1, "R8 final sweep");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule